// File: doc/BRIEF.md
# Ratio-Coded Stochastic Adder/Subtractor

This block adds or subtracts two values. Each value is held as a pair of binary words: a numerator and a denominator. Inside the block every word becomes a bipolar stochastic stream, and each operand stands for the quotient of its two stream values. A single `start` latches the four operand words and the mode, and then opens an evaluation window of 2^CNT_W clock cycles.

During the window, the numerator of the result is formed from two cross products. The denominator is formed from the product of the two operand denominators. Two up-counters count the ones in the numerator and denominator streams. When the window closes, `done` pulses and both counts are held for the consumer. The consumer turns each count c into the bipolar value 2c/2^CNT_W - 1 and divides them. That quotient can go beyond the usual bipolar range of [-1, 1].

A control machine has three states: `ST_IDLE`, `ST_RUN` and `ST_DONE`. Its transitions are:
- start-accept: `ST_IDLE` or `ST_DONE` goes to `ST_RUN` when `start` is high.
- window-end: `ST_RUN` goes to `ST_DONE` in the last window cycle.
- drain: `ST_DONE` goes to `ST_IDLE` when `start` is low.

Top module: `rsa_ratio_addsub`

## Requirements
- R1: An operand word w makes a stream whose ones occur with probability w/2^OPW, so its bipolar value is w/2^(OPW-1) - 1. The four words and `sub_sel` are captured when a start is accepted, and later changes to them have no effect on the running window.
- R2: The numerator stream picks, with an even random select, either the XNOR of the x-numerator and y-denominator streams, or the XNOR of the y-numerator and x-denominator streams. In subtract mode (`sub_sel`=1) the second product is inverted. This gives a bipolar value of (xn·yd ± yn·xd)/2.
- R3: The denominator stream picks, with the same select, either the XNOR of the two denominator streams or a zero-valued stream. Its bipolar value is xd·yd/2.
- R4: Each result counter adds one for every one-bit during `ST_RUN`. It has CNT_W+1 bits and never exceeds 2^CNT_W.
- R5: `done` is high for exactly one cycle. It rises on the clock edge 2^CNT_W cycles after the edge that accepted the start.
- R6: An accepted start clears both counts to zero. After `done`, both counts hold until the next accepted start.
- R7: A `start` during `ST_RUN` is ignored and does not move the end of the window.
- R8: With CNT_W=16, the decoded quotient (2n/2^16-1)/(2d/2^16-1) is within 5% of xn/xd ± yn/yd, including results above 1.
- R9: After reset the machine is in `ST_IDLE`, `done` is low and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a window when not running |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| x_num | input | OPW | First operand numerator word |
| x_den | input | OPW | First operand denominator word |
| y_num | input | OPW | Second operand numerator word |
| y_den | input | OPW | Second operand denominator word |
| num_count | output | CNT_W+1 | Ones counted on the result numerator stream |
| den_count | output | CNT_W+1 | Ones counted on the result denominator stream |
| done | output | 1 | One-cycle pulse when the window closes |

## Verification
The counts are final, and `done` is high, on the clock edge 2^CNT_W cycles after the edge where `start` was sampled. The driver records that edge number with each expected item it queues. The monitor samples on falling edges. It requires `done` exactly at the recorded edge and low one edge later, and it compares the counts and the decoded quotient at that point. It then checks, four cycles further on, that the counts have not moved. The clearing of the counts is observed on the falling edge right after the start is accepted.

// File: rtl/rsa_pkg.sv
package rsa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rsa_state_e;

    // four operand streams, one select stream, one zero-valued stream
    localparam int NUM_STREAMS = 6;
    localparam int NUM_OPERANDS = 4;
    localparam int IDX_SEL  = 4;
    localparam int IDX_ZERO = 5;

    // feedback masks for maximal-length Fibonacci LFSRs (bit k-1 for tap k)
    function automatic logic [31:0] tap_mask(input int width);
        case (width)
            13: return 32'h0000_100D;
            14: return 32'h0000_2015;
            15: return 32'h0000_6000;
            16: return 32'h0000_D008;
            17: return 32'h0001_2000;
            18: return 32'h0002_0400;
            19: return 32'h0004_0023;
            20: return 32'h0009_0000;
            21: return 32'h0014_0000;
            22: return 32'h0030_0000;
            23: return 32'h0042_0000;
            24: return 32'h00E1_0000;
            25: return 32'h0120_0000;
            26: return 32'h0200_0023;
            27: return 32'h0400_0013;
            28: return 32'h0900_0000;
            29: return 32'h1400_0000;
            30: return 32'h2000_0029;
            default: return 32'h0001_2000;
        endcase
    endfunction

endpackage

// File: rtl/rsa_lfsr.sv
module rsa_lfsr #(
    parameter int W    = 17,
    parameter int OW   = 16,
    parameter int SEED = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [OW-1:0] rnd
);
    import rsa_pkg::*;

    localparam logic [W-1:0] MASK   = W'(tap_mask(W));
    localparam logic [W-1:0] SEED_V = W'(SEED);

    logic [W-1:0] st_q;
    logic         fb;

    always_comb fb = ^(st_q & MASK);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEED_V;
        else        st_q <= {st_q[W-2:0], fb};
    end

    // the low OW bits form the random compare word; upper bits only feed back
    always_comb rnd = st_q[OW-1:0];

    // R1: a locked-up generator would freeze every stream
    a_r1_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0);

endmodule

// File: rtl/rsa_b2p.sv
module rsa_b2p #(
    parameter int OPW = 16
) (
    input  logic [OPW-1:0] word,
    input  logic [OPW-1:0] rnd,
    output logic           bit_o
);
    // one with probability word/2^OPW for a uniform compare word
    always_comb bit_o = (rnd < word);
endmodule

// File: rtl/rsa_p2b.sv
module rsa_p2b #(
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           en,
    input  logic           pulse,
    output logic [CNT_W:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (en && pulse) cnt <= cnt + 1'b1;
    end

    // R4: the count moves by at most one per cycle
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

    // R4: a window of 2^CNT_W cycles cannot overflow the count
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (CNT_W+1)'(2**CNT_W));

    // R6: a clear empties the count
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);

endmodule

// File: rtl/rsa_ratio_addsub.sv
module rsa_ratio_addsub
    import rsa_pkg::*;
#(
    parameter int OPW   = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sub_sel,
    input  logic [OPW-1:0]   x_num,
    input  logic [OPW-1:0]   x_den,
    input  logic [OPW-1:0]   y_num,
    input  logic [OPW-1:0]   y_den,
    output logic [CNT_W:0]   num_count,
    output logic [CNT_W:0]   den_count,
    output logic             done
);
    localparam logic [OPW-1:0] HALF_WORD = OPW'(1) << (OPW-1);

    rsa_state_e state, state_nxt;

    logic             start_acc;
    logic             running;
    logic [CNT_W-1:0] win_cnt;
    logic             win_last;
    logic             mode_q;
    logic [OPW-1:0]   op_q   [NUM_OPERANDS];
    logic [OPW-1:0]   word_s [NUM_STREAMS];
    logic [OPW-1:0]   rnd    [NUM_STREAMS];
    logic [NUM_STREAMS-1:0] sbit;

    logic prod_a, prod_b, prod_b_sgn, prod_d;
    logic num_bit, den_bit;

    always_comb begin
        running   = (state == ST_RUN);
        start_acc = start && !running;
        win_last  = &win_cnt;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions: start-accept, window-end, drain
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start)    state_nxt = ST_RUN;
            ST_RUN:  if (win_last) state_nxt = ST_DONE;
            ST_DONE: state_nxt = start ? ST_RUN : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb done = (state == ST_DONE);

    // operand capture and window timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
            mode_q  <= 1'b0;
            for (int i = 0; i < NUM_OPERANDS; i++) op_q[i] <= '0;
        end else if (start_acc) begin
            win_cnt <= '0;
            mode_q  <= sub_sel;
            op_q[0] <= x_num;
            op_q[1] <= x_den;
            op_q[2] <= y_num;
            op_q[3] <= y_den;
        end else if (running) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    // stream sources: each stream has its own generator length
    genvar g;
    generate
        for (g = 0; g < NUM_STREAMS; g++) begin : g_stream
            if (g < NUM_OPERANDS) begin : g_op
                always_comb word_s[g] = op_q[g];
            end else begin : g_half
                always_comb word_s[g] = HALF_WORD;
            end
            rsa_lfsr #(
                .W    (OPW + 1 + g),
                .OW   (OPW),
                .SEED (11 + 97 * g)
            ) u_lfsr (
                .clk   (clk),
                .rst_n (rst_n),
                .rnd   (rnd[g])
            );
            rsa_b2p #(.OPW(OPW)) u_b2p (
                .word  (word_s[g]),
                .rnd   (rnd[g]),
                .bit_o (sbit[g])
            );
        end
    endgenerate

    // bipolar products and scaled sums (index 0 xn, 1 xd, 2 yn, 3 yd)
    always_comb begin
        prod_a     = ~(sbit[0] ^ sbit[3]);
        prod_b     = ~(sbit[2] ^ sbit[1]);
        prod_b_sgn = mode_q ? ~prod_b : prod_b;
        prod_d     = ~(sbit[1] ^ sbit[3]);
        num_bit    = sbit[IDX_SEL] ? prod_a : prod_b_sgn;
        den_bit    = sbit[IDX_SEL] ? prod_d : sbit[IDX_ZERO];
    end

    rsa_p2b #(.CNT_W(CNT_W)) u_cnt_num (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_acc),
        .en    (running),
        .pulse (num_bit),
        .cnt   (num_count)
    );

    rsa_p2b #(.CNT_W(CNT_W)) u_cnt_den (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_acc),
        .en    (running),
        .pulse (den_bit),
        .cnt   (den_count)
    );

    // R5: completion flag lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: completion follows only the last window cycle
    a_r5_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(running) && $past(win_last));

    // R7: a start mid-window does not end or restart the window
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start && !win_last) |=> running && (win_cnt == $past(win_cnt) + 1'b1));

    // R1: captured operands stay fixed while running
    a_r1_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(op_q[0]) && $stable(op_q[1]) && $stable(op_q[2])
                    && $stable(op_q[3]) && $stable(mode_q));

    // R6: counts hold outside the window unless a start is accepted
    a_r6_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> $stable(num_count) && $stable(den_count));

endmodule

// File: tb/rsa_ratio_addsub_tb.sv
`timescale 1ns/1ps
module rsa_ratio_addsub_tb;
    localparam int OPW   = 16;
    localparam int CNT_W = 16;
    localparam int WIN   = 1 << CNT_W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             sub_sel = 1'b0;
    logic [OPW-1:0]   x_num = '0, x_den = '0, y_num = '0, y_den = '0;
    logic [CNT_W:0]   num_count, den_count;
    logic             done;

    rsa_ratio_addsub #(.OPW(OPW), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sub_sel(sub_sel),
        .x_num(x_num), .x_den(x_den), .y_num(y_num), .y_den(y_den),
        .num_count(num_count), .den_count(den_count), .done(done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        real   ideal;
        real   nb;
        real   db;
        int    due;
        string due_req;
    } exp_t;

    exp_t sbq[$];
    int n_chk = 0, n_bad = 0, n_done = 0;

    task automatic chk(input bit ok, input string rq, input real act, input real expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %f expected %f", rq, act, expv);
        end
    endtask

    function automatic real bip(input logic [OPW-1:0] w);
        return real'(w) / real'(1 << (OPW-1)) - 1.0;
    endfunction

    function automatic real cbip(input logic [CNT_W:0] c);
        return 2.0 * real'(c) / real'(WIN) - 1.0;
    endfunction

    function automatic real fabs(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    // driver: pushes the expected item, then applies the operation
    task automatic run_op(input logic [OPW-1:0] xn, input logic [OPW-1:0] xd,
                          input logic [OPW-1:0] yn, input logic [OPW-1:0] yd,
                          input bit sub, input bit disturb);
        exp_t e;
        real  s;
        int   target;
        s = sub ? -1.0 : 1.0;
        e.ideal = bip(xn) / bip(xd) + s * bip(yn) / bip(yd);
        e.nb    = (bip(xn) * bip(yd) + s * bip(yn) * bip(xd)) / 2.0;
        e.db    = bip(xd) * bip(yd) / 2.0;
        e.due_req = disturb ? "R7 window end with mid-run start" : "R5 done timing";
        target = n_done + 1;
        @(negedge clk);
        x_num = xn; x_den = xd; y_num = yn; y_den = yd; sub_sel = sub;
        start = 1'b1;
        e.due = cyc + 1 + WIN;
        sbq.push_back(e);
        @(negedge clk);
        start = 1'b0;
        chk(num_count == 0 && den_count == 0, "R6 start clears counts",
            real'(num_count + den_count), 0.0);
        if (disturb) begin
            repeat (1000) @(negedge clk);
            // R1 and R7: new words, flipped mode and a start while running
            x_num = 16'h1000; x_den = 16'h9000; y_num = 16'hF000; y_den = 16'h8800;
            sub_sel = ~sub;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (n_done == target);
    endtask

    // monitor: pops expected items when a result is produced
    initial begin
        forever begin
            @(negedge clk);
            if (done && sbq.size() > 0) begin
                exp_t e;
                logic [CNT_W:0] nc, dc;
                real vn, vd, r;
                e = sbq.pop_front();
                nc = num_count; dc = den_count;
                vn = cbip(nc); vd = cbip(dc); r = vn / vd;
                chk(cyc == e.due, e.due_req, real'(cyc), real'(e.due));
                chk(nc <= WIN && dc <= WIN, "R4 counts within window length",
                    real'(nc > dc ? nc : dc), real'(WIN));
                chk(fabs(vn - e.nb) <= 0.025, "R2 numerator bipolar value", vn, e.nb);
                chk(fabs(vd - e.db) <= 0.025, "R3 denominator bipolar value", vd, e.db);
                chk(fabs(r - e.ideal) <= 0.05 * fabs(e.ideal),
                    "R8 decoded ratio (R1 captured operands)", r, e.ideal);
                @(negedge clk);
                chk(!done, "R5 done one cycle wide", real'(done), 0.0);
                repeat (4) @(negedge clk);
                chk(num_count == nc && den_count == dc, "R6 counts hold after done",
                    real'(num_count), real'(nc));
                n_done++;
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done, "R9 done low after reset", real'(done), 0.0);
        chk(num_count == 0 && den_count == 0, "R9 counts zero after reset",
            real'(num_count + den_count), 0.0);
        // add: 0.5/0.95 + 0.4/0.9, operands changed mid-run
        run_op(16'd49152, 16'd63898, 16'd45875, 16'd62259, 1'b0, 1'b1);
        // subtract: 0.7/0.9 - (-0.3)/0.95, result above 1
        run_op(16'd55706, 16'd62259, 16'd22938, 16'd63898, 1'b1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule